// File: doc/BRIEF.md
# Frame Alignment Evaluator

This block measures how far an externally supplied frame pulse lags the chip's own frame timing. Logic outside the block picks one stream's frame pulse from as many as sixteen and routes it to the single measured-pulse input. The internal frame timing arrives as a one-cycle pulse at the start of each internal frame.

Software runs a measurement through a start-control bit. It holds the bit low for at least one whole internal frame, which arms the block. It then raises the bit. The evaluation window opens at the next internal frame pulse and stays open for two internal frames. The block counts clock cycles from the opening pulse to the first rising edge of the measured pulse.

When the window closes, the block raises a completion flag and places the 12-bit offset in its status word. Both stay there until software drops the start bit. Dropping the bit also ends any measurement that is still running.

Top module: `frame_align_eval`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the status word `alignStatus` reads all zeros. Bit 12 of `alignStatus` is the completion flag and bits 11:0 are the offset.
- R2: A rising edge of `startBit` begins a measurement only if `startBit` was low through one complete internal frame before it. That means low at two successive `frameStart` pulses and in every cycle between them. Any other rising edge is ignored, and the completion flag never rises because of it.
- R3: Call F0 the first `frameStart` pulse after an accepted rising edge. The completion flag (bit 12) goes high in the cycle after the second `frameStart` pulse that follows F0.
- R4: The offset (bits 11:0) equals the number of clock cycles from the F0 cycle to the first cycle in which `measPulse` is high after being low. An edge in the F0 cycle itself gives 0. Edges before F0 are not counted.
- R5: Only the first rising edge of `measPulse` inside the two-frame window sets the offset. Later edges inside the window, and edges after it closes, leave the offset unchanged.
- R6: The offset saturates at 4095 when the first edge comes 4095 or more cycles after F0.
- R7: If `measPulse` has no rising edge inside the window, the offset reads 4095 (all ones).
- R8: The completion flag and the offset hold for as long as `startBit` stays high. In the cycle after `startBit` is seen low, the whole status word reads zero.
- R9: Dropping `startBit` low while a measurement is in progress abandons it, and no completion is reported. A rising edge that follows the abandonment without a new full low frame is ignored, as R2 requires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse that marks the start of each internal frame |
| measPulse | input | 1 | Frame pulse under measurement, already selected outside the block |
| startBit | input | 1 | Software start control; a rising edge requests a measurement |
| alignStatus | output | 13 | Bit 12 is the completion flag; bits 11:0 are the measured offset |

## Verification
The assertions assume that `frameStart` is a single-cycle pulse and that every input is synchronous to `clk`. They also assume that software changes `startBit` only at the frame-level rate the handshake expects. The bench drives every input on the falling edge. It builds each frame from exactly one `frameStart` cycle followed by idle cycles, and it gives `measPulse` only single-cycle highs, so each high produces exactly one rising edge. Frame lengths vary between scenarios but always stay well above one cycle. This keeps frame boundaries and pulse edges unambiguous for both the assertions and the scoreboard.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;

  // Strobes from the control FSM to the measurement datapath
  typedef struct packed {
    logic clear;   // opening frame pulse: restart counter and capture
    logic count;   // window running: advance the cycle counter
    logic window;  // an edge seen this cycle may be captured
    logic finish;  // window closed: publish the captured value
    logic drop;    // measurement abandoned or acknowledged: clear result
  } evalStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_MEAS = 2'd2,
    ST_DONE = 2'd3
  } evalState_t;

endpackage

// File: rtl/frame_align_ctrl.sv
module frame_align_ctrl
  import frame_align_pkg::*;
#(
  parameter int EVAL_FRAMES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        startBit,
  output evalStrobe_t strb,
  output logic        done
);

  localparam int FC_W = (EVAL_FRAMES > 1) ? $clog2(EVAL_FRAMES) : 1;
  localparam logic [FC_W-1:0] LAST_FRAME = FC_W'(EVAL_FRAMES - 1);

  evalState_t      stateQ, stateD;
  logic [FC_W-1:0] frameCntQ, frameCntD;
  logic            startQ;
  logic            lowWholeQ;  // start low ever since the last frame pulse
  logic            armedQ;     // a full low frame has been observed
  logic            startRise;

  assign startRise = startBit && !startQ;
  assign done      = (stateQ == ST_DONE);

  // Arming: needs start low across one complete frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ    <= 1'b0;
      lowWholeQ <= 1'b0;
      armedQ    <= 1'b0;
    end else begin
      startQ <= startBit;
      if (startBit) begin
        lowWholeQ <= 1'b0;
        armedQ    <= 1'b0;
      end else if (frameStart) begin
        armedQ    <= armedQ | lowWholeQ;
        lowWholeQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stateD    = stateQ;
    frameCntD = frameCntQ;
    strb      = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startRise && armedQ) stateD = ST_SYNC;
      end
      ST_SYNC: begin
        if (!startBit) begin
          stateD    = ST_IDLE;
          strb.drop = 1'b1;
        end else if (frameStart) begin
          stateD      = ST_MEAS;
          frameCntD   = '0;
          strb.clear  = 1'b1;
          strb.window = 1'b1;
        end
      end
      ST_MEAS: begin
        if (!startBit) begin
          stateD    = ST_IDLE;
          strb.drop = 1'b1;
        end else begin
          strb.count = 1'b1;
          if (frameStart && (frameCntQ == LAST_FRAME)) begin
            stateD      = ST_DONE;
            strb.finish = 1'b1;
          end else begin
            strb.window = 1'b1;
            if (frameStart) frameCntD = frameCntQ + 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (!startBit) begin
          stateD    = ST_IDLE;
          strb.drop = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      frameCntQ <= '0;
    end else begin
      stateQ    <= stateD;
      frameCntQ <= frameCntD;
    end
  end

  AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && startRise && !armedQ) |=> (stateQ == ST_IDLE)); // R2

  AST_DONE_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(frameStart)); // R3

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && startBit) |=> done); // R8

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |=> !done); // R8

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_SYNC || stateQ == ST_MEAS) && !startBit) |=> (stateQ == ST_IDLE)); // R9

endmodule

// File: rtl/frame_align_dpath.sv
module frame_align_dpath
  import frame_align_pkg::*;
#(
  parameter int OFFSET_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                measPulse,
  input  evalStrobe_t         strb,
  output logic [OFFSET_W-1:0] offset
);

  localparam logic [OFFSET_W-1:0] SAT_VAL = '1;

  logic                measQ;
  logic                measRise;
  logic [OFFSET_W-1:0] cntQ;
  logic [OFFSET_W-1:0] capturedQ;
  logic                gotItQ;
  logic [OFFSET_W-1:0] resultQ;

  assign measRise = measPulse && !measQ;
  assign offset   = resultQ;

  // Cycles since the opening frame pulse, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      measQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      measQ <= measPulse;
      if (strb.clear)
        cntQ <= OFFSET_W'(1);
      else if (strb.count && cntQ != SAT_VAL)
        cntQ <= cntQ + 1'b1;
    end
  end

  // First-edge capture; all ones stands for "no edge yet"
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gotItQ    <= 1'b0;
      capturedQ <= SAT_VAL;
    end else if (strb.clear) begin
      gotItQ    <= measRise;
      capturedQ <= measRise ? '0 : SAT_VAL;
    end else if (strb.window && measRise && !gotItQ) begin
      gotItQ    <= 1'b1;
      capturedQ <= cntQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resultQ <= '0;
    else if (strb.drop)   resultQ <= '0;
    else if (strb.finish) resultQ <= capturedQ;
  end

  AST_FIRST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (gotItQ && !strb.clear) |=> $stable(capturedQ)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.count && !strb.clear && cntQ == SAT_VAL) |=> (cntQ == SAT_VAL)); // R6

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.clear, strb.finish, strb.drop}) <= 1); // R3

endmodule

// File: rtl/frame_align_eval.sv
module frame_align_eval
  import frame_align_pkg::*;
#(
  parameter int OFFSET_W    = 12,
  parameter int EVAL_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              measPulse,
  input  logic              startBit,
  output logic [OFFSET_W:0] alignStatus
);

  evalStrobe_t         strb;
  logic                done;
  logic [OFFSET_W-1:0] offset;

  frame_align_ctrl #(
    .EVAL_FRAMES(EVAL_FRAMES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .startBit   (startBit),
    .strb       (strb),
    .done       (done)
  );

  frame_align_dpath #(
    .OFFSET_W(OFFSET_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .measPulse (measPulse),
    .strb      (strb),
    .offset    (offset)
  );

  assign alignStatus = {done, offset};

endmodule

// File: tb/frame_align_eval_tb.sv
`timescale 1ns/1ps
module frame_align_eval_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        measPulse = 1'b0;
  logic        startBit = 1'b0;
  logic [12:0] alignStatus;

  int          nChecks = 0;
  int          nFails = 0;
  longint      cyc = 0;
  bit          ended = 0;
  logic        prevDone = 1'b0;

  int          expOffQ[$];
  longint      expCycQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_align_eval u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .measPulse  (measPulse),
    .startBit   (startBit),
    .alignStatus(alignStatus)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when the completion flag rises
  always @(negedge clk) begin
    if (rstN && !ended) begin
      if (alignStatus[12] && !prevDone) begin
        if (expOffQ.size() == 0) begin
          check("R2/R9 unexpected completion", 1, 0);
        end else begin
          check("R3 completion cycle", cyc, expCycQ.pop_front());
          check("R4 offset", alignStatus[11:0], expOffQ.pop_front());
        end
      end
      prevDone <= alignStatus[12];
    end
  end

  task automatic runFrame(input int len, input int pulseAt);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frameStart = (i == 0);
      measPulse  = (i == pulseAt);
    end
  endtask

  task automatic gap(input int n, input logic st, input int pulseAt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      startBit   = st;
      frameStart = 1'b0;
      measPulse  = (i == pulseAt);
    end
  endtask

  // Driver: full handshake, pushes the expected result before the closing frame
  task automatic doMeas(input int per0, input int per1, input int p0, input int p1);
    int expOff;
    if (p0 >= 0)      expOff = p0;
    else if (p1 >= 0) expOff = per0 + p1;
    else              expOff = 4095;          // R7
    if (expOff > 4095) expOff = 4095;         // R6
    gap(2, 1'b0, -1);
    runFrame(per0, -1);
    runFrame(per0, -1);
    gap(3, 1'b1, 0);                          // R4 edge before F0 is ignored
    runFrame(per0, p0);                       // F0
    runFrame(per1, p1);                       // F1
    expOffQ.push_back(expOff);
    expCycQ.push_back(cyc + 2);
    runFrame(per1, 1);                        // R5 edge after window ignored
    gap(4, 1'b1, 1);
    @(negedge clk);
    check("R8 flag holds", alignStatus[12], 1);
    check("R8 offset holds", alignStatus[11:0], expOff);
    startBit = 1'b0;
    @(negedge clk);
    check("R8 cleared after start low", alignStatus, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status in reset", alignStatus, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after reset", alignStatus, 0);

    doMeas(20, 20, 5, -1);      // R4 plain offset
    doMeas(20, 20, 0, -1);      // R4 edge on F0 cycle
    doMeas(20, 24, -1, 3);      // R4 edge in second frame
    doMeas(20, 20, 7, 2);       // R5 first edge wins
    doMeas(18, 18, -1, -1);     // R7 no edge
    doMeas(3000, 3000, -1, 1500); // R6 saturation

    // R2: rise after less than a full low frame is ignored
    gap(5, 1'b0, -1);
    runFrame(20, -1);
    gap(3, 1'b1, -1);
    runFrame(20, 4);
    runFrame(20, 4);
    runFrame(20, 4);
    gap(3, 1'b1, -1);
    check("R2 unarmed rise ignored", alignStatus, 0);

    // R9: abort mid-measurement, immediate re-raise ignored
    gap(2, 1'b0, -1);
    runFrame(20, -1);
    runFrame(20, -1);
    gap(3, 1'b1, -1);
    runFrame(20, 4);
    gap(5, 1'b0, -1);
    check("R9 abort shows nothing", alignStatus, 0);
    gap(2, 1'b1, -1);
    runFrame(20, 6);
    runFrame(20, 6);
    runFrame(20, 6);
    gap(3, 1'b1, -1);
    check("R9 re-raise ignored", alignStatus, 0);

    doMeas(16, 16, -1, 15);     // R2 recovery after a fresh low frame

    gap(4, 1'b0, -1);
    check("R3 scoreboard drained", expOffQ.size(), 0);
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!ended) begin
      ended = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule